// File: doc/BRIEF.md
# UART Receive and Status Interrupt Unit

This block raises the interrupt for one UART channel and decides which event is reported first. It takes the receive FIFO fill count and compares it with a threshold. The threshold comes from one of four trigger tables: three fixed tables and one whose level is programmed by the user. Five further interrupt causes arrive as single-cycle event pulses. Each pulse is held in a pending flag until software services it.

The six sources have a fixed ranking. A status code shows the best-ranked source that is both pending and enabled. Software acknowledges a source by reading that code: the read strobe clears only the source currently shown, so sources of lower rank appear one after another on later reads. The receive-ready source is a level and not a latched flag. It follows the fill count and is unaffected by reads. The FIFO itself, the serializer and the baud generator are outside this block.

Top module: `uart_irq_unit`

## Requirements
- R1: With table code `tbl_sel_i`=0, level codes 0,1,2,3 of `lvl_sel_i` give receive thresholds of 1, 4, 8 and 14 entries.
- R2: Table code 1 gives thresholds 8, 16, 24, 28 for level codes 0..3, and table code 2 gives thresholds 8, 16, 56, 60.
- R3: Table code 3 ignores `lvl_sel_i` and uses `user_lvl_i` as the threshold, with a value of 0 treated as 1.
- R4: Source 1 (receive ready) is pending one cycle after `fifo_cnt_i` is at or above the threshold, drops one cycle after the count falls below it, and is not cleared by a read.
- R5: Sources 0, 2, 3, 4, 5 latch a one-cycle pulse on `evt_i` bits 0, 1, 2, 3, 4 respectively and show it from the next cycle on.
- R6: `stat_o` is i+1 for the lowest-numbered source i that is pending and enabled (source 0 ranks highest), and 0 when none is.
- R7: A cycle with `rd_i` high clears only the latched source whose code `stat_o` shows in that cycle, so the next lower pending source is shown next. A read while `stat_o` is 0 changes nothing.
- R8: An event that arrives in the same cycle as the read clearing its own source stays pending.
- R9: `irq_o` is high exactly when some source is both pending and enabled in `ien_i`. A disabled source stays pending and is reported once it is enabled.
- R10: During and right after reset no source is pending, `stat_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_cnt_i | input | CNT_W | Receive FIFO fill count |
| evt_i | input | 5 | Event pulses for sources 0, 2, 3, 4, 5 |
| ien_i | input | 6 | Per-source enable, bit i for source i |
| tbl_sel_i | input | 2 | Trigger table select (0..2 fixed, 3 programmable) |
| lvl_sel_i | input | 2 | Level select within the fixed tables |
| user_lvl_i | input | 8 | Programmed threshold for table 3 |
| rd_i | input | 1 | Status read strobe, one cycle |
| stat_o | output | 3 | Code of the reported source, 0 for none |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can fall in the same cycle: a status read that clears a latched source, and a new pulse for that same source. The bench provokes this by raising `rd_i` and the event bit together while that source is being shown. It then expects the same code again on the next cycle, and expects a second, plain read to empty the status. The bench also reads while receive-ready is shown with a lower source pending. This confirms that the level source survives the read and that the lower source stays hidden until the count drops.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC    = 6;
    localparam int NEVT    = NSRC - 1;
    localparam int CODE_W  = $clog2(NSRC + 1);

    // source ranking, index 0 is served first
    localparam int SRC_LINE_ERR = 0;
    localparam int SRC_RX_READY = 1;
    localparam int SRC_RX_IDLE  = 2;
    localparam int SRC_TX_EMPTY = 3;
    localparam int SRC_MODEM    = 4;
    localparam int SRC_SPECIAL  = 5;

    typedef struct packed {
        logic [NSRC-1:0] pend;
    } irq_state_t;

endpackage

// File: rtl/irq_trig_sel.sv
module irq_trig_sel #(
    parameter int CNT_W = 8
) (
    input  logic [1:0]       tbl_sel_i,
    input  logic [1:0]       lvl_sel_i,
    input  logic [7:0]       user_lvl_i,
    output logic [CNT_W-1:0] thr_o
);

    logic [7:0] lvl8;

    // R1 R2 R3: threshold selection
    always_comb begin
        lvl8 = 8'd1;
        unique case (tbl_sel_i)
            2'd0: begin
                unique case (lvl_sel_i)
                    2'd0: lvl8 = 8'd1;
                    2'd1: lvl8 = 8'd4;
                    2'd2: lvl8 = 8'd8;
                    default: lvl8 = 8'd14;
                endcase
            end
            2'd1: begin
                unique case (lvl_sel_i)
                    2'd0: lvl8 = 8'd8;
                    2'd1: lvl8 = 8'd16;
                    2'd2: lvl8 = 8'd24;
                    default: lvl8 = 8'd28;
                endcase
            end
            2'd2: begin
                unique case (lvl_sel_i)
                    2'd0: lvl8 = 8'd8;
                    2'd1: lvl8 = 8'd16;
                    2'd2: lvl8 = 8'd56;
                    default: lvl8 = 8'd60;
                endcase
            end
            default: lvl8 = (user_lvl_i == 8'd0) ? 8'd1 : user_lvl_i;
        endcase
    end

    assign thr_o = CNT_W'(lvl8);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 6,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req_i,
    output logic [CW-1:0] code_o
);

    // R6: lowest index wins, code is index plus one
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = CW'(i + 1);
        end
    end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] fifo_cnt_i,
    input  logic [NEVT-1:0]  evt_i,
    input  logic [NSRC-1:0]  ien_i,
    input  logic [1:0]       tbl_sel_i,
    input  logic [1:0]       lvl_sel_i,
    input  logic [7:0]       user_lvl_i,
    input  logic             rd_i,
    output logic [CODE_W-1:0] stat_o,
    output logic             irq_o
);

    irq_state_t      st_d, st_q;
    logic [CNT_W-1:0] thr;
    logic [NSRC-1:0]  active;

    irq_trig_sel #(.CNT_W(CNT_W)) u_trig (
        .tbl_sel_i (tbl_sel_i),
        .lvl_sel_i (lvl_sel_i),
        .user_lvl_i(user_lvl_i),
        .thr_o     (thr)
    );

    assign active = st_q.pend & ien_i;

    irq_prio_enc #(.N(NSRC), .CW(CODE_W)) u_enc (
        .req_i (active),
        .code_o(stat_o)
    );

    assign irq_o = |active;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            if (i == SRC_RX_READY) begin
                // R4: level source follows the count
                st_d.pend[i] = (fifo_cnt_i >= thr);
            end else begin
                // R5 R7 R8: set beats clear
                st_d.pend[i] = (st_q.pend[i] && !(rd_i && stat_o == CODE_W'(i + 1)))
                             || evt_i[(i > SRC_RX_READY) ? i - 1 : i];
            end
        end
    end

    // R10
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R9
    irq_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (stat_o != '0));

    // R6
    prio_rank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_o != '0) |-> (active[stat_o - CODE_W'(1)]
            && ((active & ((NSRC'(1) << (stat_o - CODE_W'(1))) - NSRC'(1))) == '0)));

    for (genvar g = 0; g < NSRC; g++) begin : g_src_chk
        if (g != SRC_RX_READY) begin : g_evt
            localparam int EB = (g > SRC_RX_READY) ? g - 1 : g;
            // R5 R8
            evt_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                evt_i[EB] |=> st_q.pend[g]);
            // R7
            read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (rd_i && stat_o == CODE_W'(g + 1) && !evt_i[EB]) |=> !st_q.pend[g]);
        end
    end

endmodule

// File: tb/tb_uart_irq_unit.sv
module tb_uart_irq_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] fifo_cnt;
    logic [4:0] evt;
    logic [5:0] ien;
    logic [1:0] tbl_sel, lvl_sel;
    logic [7:0] user_lvl;
    logic       rd;
    logic [2:0] stat;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_unit #(.CNT_W(8)) dut (
        .clk_i(clk), .rst_ni(rst_n), .fifo_cnt_i(fifo_cnt), .evt_i(evt),
        .ien_i(ien), .tbl_sel_i(tbl_sel), .lvl_sel_i(lvl_sel),
        .user_lvl_i(user_lvl), .rd_i(rd), .stat_o(stat), .irq_o(irq)
    );

    typedef struct packed {
        logic [1:0] tbl;
        logic [1:0] lvl;
        logic [7:0] usr;
        logic [7:0] cnt;
        logic [2:0] exp;
    } vec_t;

    // only source 1 enabled, code 2 means receive ready
    localparam vec_t VEC [24] = '{
        '{2'd0, 2'd0, 8'd0,   8'd0,   3'd0}, '{2'd0, 2'd0, 8'd0,   8'd1,   3'd2},
        '{2'd0, 2'd1, 8'd0,   8'd3,   3'd0}, '{2'd0, 2'd1, 8'd0,   8'd4,   3'd2},
        '{2'd0, 2'd2, 8'd0,   8'd7,   3'd0}, '{2'd0, 2'd2, 8'd0,   8'd8,   3'd2},
        '{2'd0, 2'd3, 8'd0,   8'd13,  3'd0}, '{2'd0, 2'd3, 8'd0,   8'd14,  3'd2},
        '{2'd1, 2'd0, 8'd0,   8'd7,   3'd0}, '{2'd1, 2'd0, 8'd0,   8'd8,   3'd2},
        '{2'd1, 2'd1, 8'd0,   8'd15,  3'd0}, '{2'd1, 2'd1, 8'd0,   8'd16,  3'd2},
        '{2'd1, 2'd2, 8'd0,   8'd23,  3'd0}, '{2'd1, 2'd2, 8'd0,   8'd24,  3'd2},
        '{2'd1, 2'd3, 8'd0,   8'd27,  3'd0}, '{2'd1, 2'd3, 8'd0,   8'd28,  3'd2},
        '{2'd2, 2'd2, 8'd0,   8'd55,  3'd0}, '{2'd2, 2'd2, 8'd0,   8'd56,  3'd2},
        '{2'd2, 2'd3, 8'd0,   8'd59,  3'd0}, '{2'd2, 2'd3, 8'd0,   8'd60,  3'd2},
        '{2'd3, 2'd0, 8'd0,   8'd0,   3'd0}, '{2'd3, 2'd0, 8'd0,   8'd1,   3'd2},
        '{2'd3, 2'd0, 8'd200, 8'd199, 3'd0}, '{2'd3, 2'd0, 8'd200, 8'd200, 3'd2}
    };

    task automatic chk(input string rq, input logic [2:0] exp_s, input logic exp_i);
        n_run++;
        if (stat !== exp_s || irq !== exp_i) begin
            n_fail++;
            $display("FAIL %s stat=%0d irq=%0b expected stat=%0d irq=%0b",
                     rq, stat, irq, exp_s, exp_i);
        end
    endtask

    task automatic pulse(input logic [4:0] m);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic do_read(input logic [4:0] m);
        rd  = 1'b1;
        evt = m;
        @(negedge clk);
        rd  = 1'b0;
        evt = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fifo_cnt = '0; evt = '0; ien = 6'b000010;
        tbl_sel = '0; lvl_sel = '0; user_lvl = '0; rd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 in reset", 3'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", 3'd0, 1'b0);

        // R1 R2 R3 R4: threshold vectors
        for (int k = 0; k < 24; k++) begin
            tbl_sel = VEC[k].tbl; lvl_sel = VEC[k].lvl;
            user_lvl = VEC[k].usr; fifo_cnt = VEC[k].cnt;
            @(negedge clk);
            chk($sformatf("R1/R2/R3/R4 vector %0d", k), VEC[k].exp, VEC[k].exp != 0);
        end

        tbl_sel = 2'd0; lvl_sel = 2'd0; fifo_cnt = '0; ien = 6'b111111;
        @(negedge clk);
        chk("R4 count below threshold", 3'd0, 1'b0);

        // R5 R6: sources 3 and 5 together, then source 0
        pulse(5'b10100);
        chk("R5 R6 code of source 3", 3'd4, 1'b1);
        pulse(5'b00001);
        chk("R6 source 0 outranks", 3'd1, 1'b1);
        // R7: reads peel one at a time
        do_read('0);
        chk("R7 after first read", 3'd4, 1'b1);
        do_read('0);
        chk("R7 after second read", 3'd6, 1'b1);
        do_read('0);
        chk("R7 after third read", 3'd0, 1'b0);
        do_read('0);
        chk("R7 read while empty", 3'd0, 1'b0);

        // R8: new event for the source being cleared
        pulse(5'b00010);
        chk("R8 source 2 pending", 3'd3, 1'b1);
        do_read(5'b00010);
        chk("R8 event kept through read", 3'd3, 1'b1);
        do_read('0);
        chk("R8 plain read clears", 3'd0, 1'b0);

        // R4: level source not cleared by read
        fifo_cnt = 8'd5;
        pulse(5'b00100);
        chk("R4 ready outranks source 3", 3'd2, 1'b1);
        do_read('0);
        chk("R4 ready survives read", 3'd2, 1'b1);
        fifo_cnt = 8'd0;
        @(negedge clk);
        chk("R4 ready drops, R7 source 3 kept", 3'd4, 1'b1);
        do_read('0);
        chk("R7 source 3 cleared", 3'd0, 1'b0);

        // R9: masked source stays pending
        ien = 6'b110111;
        pulse(5'b00100);
        chk("R9 disabled source hidden", 3'd0, 1'b0);
        ien = 6'b111111;
        @(negedge clk);
        chk("R9 enabled source shown", 3'd4, 1'b1);
        do_read('0);
        chk("R9 cleared", 3'd0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule